// File: doc/BRIEF.md
# Host-Settable Device Timestamp

This block keeps a device time value that host software can load and read back through a mailbox-style command channel. A free-running nanosecond counter advances by a fixed step on every clock in which the tick input is high. A set command carries a 64-bit host time. The block keeps that time together with the counter value it saw when the command was accepted.

A get command returns the host time plus the nanoseconds that have passed since that set, as an 8-byte payload. Before any set has been accepted, a get returns zero rather than a running count. A command whose byte count does not fit its kind is refused with an error status and changes nothing.

Commands enter on a valid/ready channel and results leave on a second valid/ready channel. The result is held in a single output slot. A new command is accepted only when that slot is empty, or when it is being emptied in the same cycle (`cmd_ready = !rsp_valid || rsp_ready`). Each result appears one clock after its command is accepted. It then stays unchanged until the consumer raises `rsp_ready`, so back-pressure on the result channel stalls the command channel and no result is lost.

Top module: `ts_host_clock`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `cmd_ready` is 1, the nanosecond counter is 0, and no result appears unless a command has been accepted.
- R2: The counter grows by STEP_NS (default 20) on each clock edge at which `tick_i` is high and holds otherwise. Time differences wrap modulo 2^64.
- R3: A get (`cmd_is_set`=0, `cmd_len`=0) accepted before any set returns `rsp_data`=0, `rsp_len`=8 and `rsp_status`=0 (OK), whatever the counter holds.
- R4: A set (`cmd_is_set`=1, `cmd_len`=8) stores `cmd_data`, captures the counter value of its accepting cycle, and marks the time as loaded. It returns `rsp_len`=0, `rsp_data`=0 and `rsp_status`=0.
- R5: A get after a set returns host value + (counter in the get's accepting cycle − captured counter), modulo 2^64.
- R6: Payloads are little-endian: byte k of the payload sits in bits [8k+7:8k] of `cmd_data` and of `rsp_data`. A get reports a length of 8 bytes.
- R7: A set with `cmd_len`≠8, or a get with `cmd_len`≠0, returns `rsp_status`=1 (bad length) with `rsp_len`=0 and `rsp_data`=0, and leaves the stored time unchanged.
- R8: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. Its result is valid from the next cycle and holds still until taken with `rsp_ready`. `cmd_ready` = !`rsp_valid` || `rsp_ready`.
- R9: A reset in mid-run forgets the loaded time, so the next get returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Counter advance enable, one STEP_NS per clock while high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_is_set | input | 1 | 1 = set time, 0 = get time |
| cmd_len | input | LEN_W | Command payload byte count |
| cmd_data | input | TS_W | Command payload, little-endian |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | TS_W | Result payload, little-endian |
| rsp_len | output | LEN_W | Result payload byte count |
| rsp_status | output | 2 | 0 = OK, 1 = bad length |

## Verification
Two pairs of events can land in the same cycle. The first pair is a result leaving the output slot while the next command is accepted into it. The second pair is a set capturing the counter on the very edge at which a tick advances it. The bench provokes the first by issuing commands back to back while `rsp_ready` drops on a fixed pattern. It provokes the second by holding `tick_i` high through sets. A scoreboard model judges both: it advances its own counter from the ticks it drives, fixes each expected value in the cycle its command is accepted, and also checks that a stalled result stays unchanged.

// File: rtl/ts_pkg.sv
package ts_pkg;

  // result status codes carried on rsp_status
  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_BAD_LEN = 2'd1
  } ts_status_e;

endpackage

// File: rtl/ts_ns_counter.sv
module ts_ns_counter #(
  parameter int W    = 64,
  parameter int STEP = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  output logic [W-1:0] now_o
);
  localparam logic [W-1:0] STEP_V = W'(STEP);

  logic [W-1:0] now_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     now_q <= '0;
    else if (adv_i) now_q <= now_q + STEP_V;
  end

  assign now_o = now_q;

  // R2: one step per enabled edge, hold otherwise
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> (now_o - $past(now_o)) == STEP_V);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(now_o));

endmodule

// File: rtl/ts_stamp_store.sv
module ts_stamp_store #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] host_i,
  input  logic [W-1:0] now_i,
  output logic         armed_o,
  output logic [W-1:0] stamp_o
);
  // host - captured counter, kept as one offset word
  logic [W-1:0] offset_q;
  logic         armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      offset_q <= '0;
    end else if (wr_i) begin
      armed_q  <= 1'b1;
      offset_q <= host_i - now_i;
    end
  end

  assign armed_o = armed_q;
  assign stamp_o = armed_q ? (now_i + offset_q) : '0;

  // R4/R5: right after a load the stamp equals host value plus counter movement
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> armed_o && stamp_o == $past(host_i) + (now_i - $past(now_i)));
  // R5: between loads the stamp moves exactly as the counter does
  p_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && !wr_i) |=> (stamp_o - $past(stamp_o)) == (now_i - $past(now_i)));

endmodule

// File: rtl/ts_rsp_slot.sv
module ts_rsp_slot #(
  parameter int W  = 64,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [W-1:0]  data_i,
  input  logic [LW-1:0] len_i,
  input  logic [1:0]    st_i,
  output logic          free_o,
  output logic          valid_o,
  input  logic          ready_i,
  output logic [W-1:0]  data_o,
  output logic [LW-1:0] len_o,
  output logic [1:0]    st_o
);
  logic          valid_q;
  logic [W-1:0]  data_q;
  logic [LW-1:0] len_q;
  logic [1:0]    st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      len_q   <= '0;
      st_q    <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
      len_q   <= len_i;
      st_q    <= st_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign free_o  = !valid_q || ready_i;
  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign len_o   = len_q;
  assign st_o    = st_q;

  // R8: a stalled result does not move
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> valid_o && $stable(data_o) && $stable(len_o) && $stable(st_o));
  // R8: a result never appears without a load
  p_fresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !load_i) |=> !valid_o);

endmodule

// File: rtl/ts_host_clock.sv
module ts_host_clock
  import ts_pkg::*;
#(
  parameter int TS_W    = 64,
  parameter int STEP_NS = 20,
  parameter int LEN_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_is_set,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [TS_W-1:0]  cmd_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [TS_W-1:0]  rsp_data,
  output logic [LEN_W-1:0] rsp_len,
  output logic [1:0]       rsp_status
);
  localparam int               PAY_BYTES = TS_W / 8;
  localparam logic [LEN_W-1:0] PAY_LEN   = LEN_W'(PAY_BYTES);

  logic              slot_free;
  logic              accept;
  logic              len_ok;
  logic              do_set;
  logic              armed;
  logic [TS_W-1:0]   now;
  logic [TS_W-1:0]   stamp;
  logic [TS_W-1:0]   nxt_data;
  logic [LEN_W-1:0]  nxt_len;
  ts_status_e        nxt_st;

  assign cmd_ready = slot_free;
  assign accept    = cmd_valid && slot_free;
  assign len_ok    = cmd_is_set ? (cmd_len == PAY_LEN) : (cmd_len == '0);
  assign do_set    = accept && cmd_is_set && len_ok;

  ts_ns_counter #(.W(TS_W), .STEP(STEP_NS)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (tick_i),
    .now_o (now)
  );

  // payload bytes are already lane-ordered little-endian on the bus
  ts_stamp_store #(.W(TS_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (do_set),
    .host_i  (cmd_data),
    .now_i   (now),
    .armed_o (armed),
    .stamp_o (stamp)
  );

  always_comb begin
    nxt_data = '0;
    nxt_len  = '0;
    nxt_st   = ST_OK;
    if (!len_ok) begin
      nxt_st = ST_BAD_LEN;
    end else if (!cmd_is_set) begin
      nxt_data = stamp;
      nxt_len  = PAY_LEN;
    end
  end

  ts_rsp_slot #(.W(TS_W), .LW(LEN_W)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept),
    .data_i  (nxt_data),
    .len_i   (nxt_len),
    .st_i    (nxt_st),
    .free_o  (slot_free),
    .valid_o (rsp_valid),
    .ready_i (rsp_ready),
    .data_o  (rsp_data),
    .len_o   (rsp_len),
    .st_o    (rsp_status)
  );

  // R7: refused commands return an empty payload
  p_badlen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == ST_BAD_LEN) |-> (rsp_len == '0 && rsp_data == '0));
  // R7: a refused command leaves the loaded state alone
  p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !len_ok) |=> $stable(armed));
  // R4: an accepted set answers with length 0 and OK
  p_setrsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    do_set |=> rsp_valid && rsp_len == '0 && rsp_status == ST_OK && armed);
  // R3: a get before any load answers zero
  p_unarmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmd_is_set && len_ok && !armed) |=> rsp_data == '0);
  // R6: a valid get reports a full payload length
  p_getlen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmd_is_set && len_ok) |=> rsp_len == PAY_LEN && rsp_status == ST_OK);

endmodule

// File: tb/ts_host_clock_bench.sv
module ts_host_clock_bench;
  localparam int W    = 64;
  localparam int STEP = 20;
  localparam int LW   = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_i = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_is_set = 1'b0;
  logic [LW-1:0] cmd_len = '0;
  logic [W-1:0]  cmd_data = '0;
  logic          rsp_ready = 1'b0;
  logic          cmd_ready;
  logic          rsp_valid;
  logic [W-1:0]  rsp_data;
  logic [LW-1:0] rsp_len;
  logic [1:0]    rsp_status;

  always #10 clk = ~clk;

  ts_host_clock #(.TS_W(W), .STEP_NS(STEP), .LEN_W(LW)) u_ts_host_clock (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_is_set (cmd_is_set),
    .cmd_len    (cmd_len),
    .cmd_data   (cmd_data),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_data   (rsp_data),
    .rsp_len    (rsp_len),
    .rsp_status (rsp_status)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  int unsigned cyc = 0;
  int          tick_mode = 0;
  int          ready_mode = 0;

  // reference model
  logic [W-1:0] m_now = '0;
  logic [W-1:0] m_host = '0;
  logic [W-1:0] m_cap = '0;
  bit           m_armed = 1'b0;

  logic [W-1:0]  q_data[$];
  logic [LW-1:0] q_len[$];
  logic [1:0]    q_st[$];
  string         q_tag[$];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n)      m_now <= '0;
    else if (tick_i) m_now <= m_now + W'(STEP);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // tick pattern driver
  initial begin
    forever begin
      @(negedge clk);
      case (tick_mode)
        0:       tick_i = 1'b0;
        1:       tick_i = 1'b1;
        default: tick_i = (cyc % 3 != 0);
      endcase
    end
  end

  // monitor: drives back-pressure, pops and compares
  initial begin
    bit            stalled;
    logic [W-1:0]  hd;
    logic [LW-1:0] hl;
    logic [1:0]    hs;
    logic [W-1:0]  ed;
    logic [LW-1:0] el;
    logic [1:0]    es;
    string         et;
    stalled = 1'b0;
    forever begin
      @(negedge clk);
      rsp_ready = (ready_mode == 0) ? 1'b1 : (cyc % 4 != 1);
      #1;
      if (!rst_n) begin
        stalled = 1'b0;
      end else begin
        if (stalled)
          check(rsp_valid && rsp_data == hd && rsp_len == hl && rsp_status == hs,
                "R8", "stalled result held", rsp_data, hd);
        if (rsp_valid && rsp_ready) begin
          if (q_data.size() == 0) begin
            check(1'b0, "R8", "result with no command", rsp_data, '0);
          end else begin
            ed = q_data.pop_front();
            el = q_len.pop_front();
            es = q_st.pop_front();
            et = q_tag.pop_front();
            check(rsp_data == ed, et, "data", rsp_data, ed);
            check(rsp_len == el, et, "length", W'(rsp_len), W'(el));
            check(rsp_status == es, et, "status", W'(rsp_status), W'(es));
          end
        end
        stalled = rsp_valid && !rsp_ready;
        hd = rsp_data;
        hl = rsp_len;
        hs = rsp_status;
      end
    end
  end

  // driver: offers one command, fixes its expected result at acceptance
  task automatic send(input bit is_set, input logic [LW-1:0] len,
                      input logic [W-1:0] data, input string tag);
    bit ok;
    @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_is_set = is_set;
    cmd_len    = len;
    cmd_data   = data;
    #2;
    while (!cmd_ready) begin
      @(negedge clk);
      #2;
    end
    ok = is_set ? (len == LW'(8)) : (len == '0);
    if (!ok) begin
      q_data.push_back('0); q_len.push_back('0); q_st.push_back(2'd1);
    end else if (is_set) begin
      q_data.push_back('0); q_len.push_back('0); q_st.push_back(2'd0);
      m_host  = data;
      m_cap   = m_now;
      m_armed = 1'b1;
    end else begin
      q_data.push_back(m_armed ? m_host + (m_now - m_cap) : '0);
      q_len.push_back(LW'(8));
      q_st.push_back(2'd0);
    end
    q_tag.push_back(tag);
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && q_data.size() != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    m_armed = 1'b0;
    rst_n   = 1'b1;
    #3;
    check(!rsp_valid, "R1", "rsp_valid after reset", W'(rsp_valid), '0);
    check(cmd_ready, "R1", "cmd_ready after reset", W'(cmd_ready), W'(1));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(20 * 60000);
    n_bad++;
    $display("FAIL R8 watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    // R1: no results while idle
    tick_mode = 1;
    repeat (10) @(negedge clk);
    #3;
    check(!rsp_valid, "R1", "idle produces no result", W'(rsp_valid), '0);

    // R3: gets before any set read zero despite a running counter
    send(1'b0, 8'd0, '0, "R3 get before set");
    drain();
    send(1'b0, 8'd0, '0, "R3 second get before set");

    // R4, R6: set then immediate get with the counter frozen returns exact bytes
    tick_mode = 0;
    send(1'b1, 8'd8, 64'h0807_0605_0403_0201, "R4 set");
    send(1'b0, 8'd0, '0, "R6 little-endian read back");
    drain();

    // R5, R2: elapsed time added after steady and gated ticks
    tick_mode = 1;
    repeat (7) @(negedge clk);
    send(1'b0, 8'd0, '0, "R5 elapsed after steady ticks");
    tick_mode = 2;
    repeat (13) @(negedge clk);
    send(1'b0, 8'd0, '0, "R2 gated tick steps");
    tick_mode = 0;
    repeat (5) @(negedge clk);
    send(1'b0, 8'd0, '0, "R2 counter holds without ticks");
    drain();

    // R7: refused lengths, then state unchanged
    send(1'b1, 8'd4, 64'hDEAD_BEEF_0000_1111, "R7 short set");
    send(1'b0, 8'd8, 64'h1234, "R7 get with payload");
    send(1'b1, 8'd0, 64'h5555, "R7 empty set");
    send(1'b0, 8'd0, '0, "R7 stored time kept");
    drain();

    // R5: modular wrap of the returned value
    tick_mode = 1;
    send(1'b1, 8'd8, 64'hFFFF_FFFF_FFFF_FFF0, "R5 set near top");
    repeat (3) @(negedge clk);
    send(1'b0, 8'd0, '0, "R5 wrapped result");
    drain();

    // R8: back-to-back stream under back-pressure, sets landing on ticks
    ready_mode = 1;
    tick_mode  = 2;
    for (int i = 0; i < 12; i++) begin
      if (i % 3 == 0) send(1'b1, 8'd8, 64'h0100_0000_0000_0000 * i + 64'(i), "R8 stream set");
      else            send(1'b0, 8'd0, '0, "R8 stream get");
    end
    drain();
    ready_mode = 0;

    // R4: set accepted on an edge where the counter also steps
    tick_mode = 1;
    send(1'b1, 8'd8, 64'h0000_0000_0000_0100, "R4 set on tick edge");
    send(1'b0, 8'd0, '0, "R4 get right after tick-edge set");
    drain();

    // R9: reset in mid-run forgets the loaded time
    do_reset();
    send(1'b0, 8'd0, '0, "R9 get after reset");
    drain();

    summary();
    $finish;
  end

endmodule